// File: doc/BRIEF.md
# Serial EEPROM Write Target (two-wire bus)

This block is the write side of a 1K x 8 serial EEPROM on a two-wire bus. The system clock oversamples the clock and data lines. The block finds start and stop conditions and decodes the device address byte. It then takes a word address and gathers one or more data bytes into a 16-byte page buffer. It acknowledges by pulling the data line low through an open-drain enable.

When a stop follows at least one data byte, the block starts a timed internal write cycle. During that cycle it copies the buffered bytes into an on-chip array and ignores the bus completely. A master polls for the end of the cycle by repeating start plus device address until the block acknowledges. A registered read port on the array lets neighbouring logic see what was committed. Read transfers on the bus are not served.

Top module: `eeprom_write_target`

## Requirements
- R1: After reset, `sdaOe` is 0 and `busy` is 0.
- R2: A device byte matches when its bits 7:4 are 4'b1010 and its bit 3 equals `strapPins[2]`. `strapPins[1:0]` have no effect on matching. A match is acknowledged by holding `sdaOe` at 1 through the ninth SCL pulse. `sdaOe` returns to 0 after that pulse.
- R3: A device byte that does not match gets no acknowledge. The block then stays silent, with no acknowledge for any later byte, until the next start.
- R4: Bit 0 of the device byte selects the operation: 0 is a write and 1 is a read. A matching read byte is acknowledged. No later byte of that transfer is acknowledged, and no write cycle follows.
- R5: After a write device byte, the next byte is the word address and every byte after that is data. All of them are acknowledged. The first data byte goes to array address {device bits 2:1, word address}.
- R6: After each data byte only the low 4 address bits advance. The address wraps from offset 15 to offset 0 of the same 16-byte page.
- R7: When more than 16 data bytes arrive in one transfer, later bytes overwrite the earlier bytes at the same page offset.
- R8: A stop that follows at least one data byte raises `busy` for exactly `WR_CYCLES` system clocks. After that, the received bytes are in the array.
- R9: A stop that comes before any data byte starts no write cycle, and `busy` stays 0.
- R10: While `busy` is 1, the block gives no acknowledge, not even to a matching device byte, and the array is not changed. After `busy` falls, a start and a matching device byte are acknowledged again.
- R11: A repeated start in the middle of a write transfer discards the data bytes gathered so far. Address decoding restarts.
- R12: `memRdData` shows the array byte at `memRdAddr` one system clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| strapPins | input | 3 | Board straps; only bit 2 takes part in matching |
| sdaOe | output | 1 | 1 pulls the data line low (acknowledge) |
| busy | output | 1 | Internal write cycle in progress |
| memRdAddr | input | ADDR_W (10) | Array read address |
| memRdData | output | 8 | Array read data, one clock after the address |

## Verification
An acknowledge appears about four system clocks after the eighth falling SCL edge: two synchronizer flops, the edge register and the output flop. The bench therefore reads the wired data line in the middle of the ninth SCL high phase, which comes at least twenty clocks after that fall. `busy` rises about four clocks after the data line rises for a stop. It is sampled ten clocks later, and its length is counted at each falling system-clock edge and compared with exactly `WR_CYCLES`. Array contents are checked only after `busy` has fallen, because the commit runs inside the cycle. Each read is sampled one clock after the address is applied, on the falling edge.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKWAIT,
    ST_ACK,
    ST_SKIP,
    ST_BUSY
  } ctlState_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WADDR,
    PH_DATA
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic clearPage;
    logic devLoad;
    logic addrLoad;
    logic dataStore;
    logic commitGo;
  } dpCmd_t;

endpackage

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int PAGE_SEL_BITS = 2,
  parameter int WR_CYCLES     = 625000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapPins,
  input  logic [7:0] rxNext,
  input  logic       pageHasData,
  output dpCmd_t     cmd,
  output logic       sdaBit,
  output logic       sdaOe,
  output logic       busy
);

  localparam int          TMR_W      = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WR_CYCLES - 1);
  localparam logic [2:0]  STRAP_MASK = 3'(7 << PAGE_SEL_BITS);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;

  ctlState_e        state;
  phase_e           phase;
  logic [2:0]       bitCnt;
  logic             isRead;
  logic [TMR_W-1:0] timer;
  logic             devMatch;

  // two-flop style synchronizers, bus idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit   = sdaS;
  assign busy     = (state == ST_BUSY);

  assign devMatch = (rxNext[7:4] == DEV_TYPE) &&
                    (((rxNext[3:1] ^ strapPins) & STRAP_MASK) == 3'b000);

  // strobes to the datapath
  always_comb begin
    cmd = '0;
    if (state != ST_BUSY) begin
      if (startDet) begin
        cmd.clearPage = 1'b1;
      end else if (stopDet) begin
        cmd.commitGo = pageHasData;
      end else if (state == ST_RECV && sclRise) begin
        cmd.shift = 1'b1;
        if (bitCnt == 3'd7) begin
          unique case (phase)
            PH_DEV:   cmd.devLoad   = devMatch & ~rxNext[0];
            PH_WADDR: cmd.addrLoad  = 1'b1;
            PH_DATA:  cmd.dataStore = 1'b1;
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_DEV;
      bitCnt <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
      timer  <= '0;
    end else if (state == ST_BUSY) begin
      sdaOe <= 1'b0;
      if (timer == TMR_LAST) begin
        timer <= '0;
        state <= ST_IDLE;
      end else begin
        timer <= timer + 1'b1;
      end
    end else if (startDet) begin
      state  <= ST_RECV;
      phase  <= PH_DEV;
      bitCnt <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      sdaOe <= 1'b0;
      timer <= '0;
      state <= pageHasData ? ST_BUSY : ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              if (phase == PH_DEV) begin
                isRead <= rxNext[0];
                state  <= devMatch ? ST_ACKWAIT : ST_SKIP;
              end else begin
                state <= ST_ACKWAIT;
              end
            end
          end
        end
        ST_ACKWAIT: begin
          if (sclFall) begin
            sdaOe <= 1'b1;
            state <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            if (isRead) begin
              state <= ST_SKIP;
            end else begin
              state <= ST_RECV;
              phase <= (phase == PH_DEV) ? PH_WADDR : PH_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10: no acknowledge while the write cycle runs
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R2: acknowledge drive starts only while SCL is low
  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  // R9: a write cycle needs buffered data
  a_r9_write_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(pageHasData));

  // R3: a transfer being skipped stays silent
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe);

endmodule

// File: rtl/eewr_data.sv
module eewr_data
  import eewr_pkg::*;
#(
  parameter int PAGE_SEL_BITS = 2,
  parameter int PAGE_BITS     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCmd_t                     cmd,
  input  logic                       sdaBit,
  output logic [7:0]                 rxNext,
  output logic                       pageHasData,
  input  logic [8+PAGE_SEL_BITS-1:0] memRdAddr,
  output logic [7:0]                 memRdData
);

  localparam int ADDR_W   = 8 + PAGE_SEL_BITS;
  localparam int BASE_W   = ADDR_W - PAGE_BITS;
  localparam int PAGE_LEN = 1 << PAGE_BITS;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam logic [PAGE_BITS-1:0] PAGE_LAST = '1;

  logic [6:0]               shiftReg;
  logic [PAGE_SEL_BITS-1:0] devPage;
  logic [BASE_W-1:0]        pageBase;
  logic [PAGE_BITS-1:0]     wordPtr;
  logic [7:0]               pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0]      pageVld;
  logic [PAGE_LEN-1:0]      slotWr;
  logic [PAGE_BITS-1:0]     commitIdx;
  logic                     commitActive;
  logic                     commitEnd;
  logic [7:0]               mem [DEPTH];

  assign rxNext      = {shiftReg, sdaBit};
  assign pageHasData = |pageVld;
  assign commitEnd   = commitActive && (commitIdx == PAGE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      devPage  <= '0;
      pageBase <= '0;
      wordPtr  <= '0;
    end else begin
      if (cmd.shift)    shiftReg <= rxNext[6:0];
      if (cmd.devLoad)  devPage  <= rxNext[PAGE_SEL_BITS:1];
      if (cmd.addrLoad) begin
        pageBase <= {devPage, rxNext[7:PAGE_BITS]};
        wordPtr  <= rxNext[PAGE_BITS-1:0];
      end else if (cmd.dataStore) begin
        wordPtr <= wordPtr + 1'b1;  // wraps inside the page
      end
    end
  end

  // per-slot write enables of the page buffer
  for (genvar i = 0; i < PAGE_LEN; i++) begin : g_slot
    assign slotWr[i] = cmd.dataStore && (wordPtr == PAGE_BITS'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageVld <= '0;
      for (int i = 0; i < PAGE_LEN; i++) pageBuf[i] <= '0;
    end else if (cmd.clearPage || commitEnd) begin
      pageVld <= '0;
    end else begin
      for (int i = 0; i < PAGE_LEN; i++) begin
        if (slotWr[i]) begin
          pageBuf[i] <= rxNext;
          pageVld[i] <= 1'b1;
        end
      end
    end
  end

  // one page slot per clock moves into the array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitActive <= 1'b0;
      commitIdx    <= '0;
    end else if (cmd.commitGo) begin
      commitActive <= 1'b1;
      commitIdx    <= '0;
    end else if (commitActive) begin
      commitIdx <= commitIdx + 1'b1;
      if (commitIdx == PAGE_LAST) commitActive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (commitActive && pageVld[commitIdx])
      mem[{pageBase, commitIdx}] <= pageBuf[commitIdx];
    memRdData <= mem[memRdAddr];
  end

  // R10: no data byte is taken while the array is being written
  a_r10_no_store_in_commit: assert property (@(posedge clk) disable iff (!rstN)
    commitActive |-> !cmd.dataStore);

  // R6: page base stays put as data bytes arrive
  a_r6_base_held: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dataStore |=> $stable(pageBase));

  // R11: a start leaves nothing buffered
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearPage |=> !pageHasData);

endmodule

// File: rtl/eeprom_write_target.sv
module eeprom_write_target
  import eewr_pkg::*;
#(
  parameter int PAGE_SEL_BITS = 2,
  parameter int PAGE_BITS     = 4,
  parameter int WR_CYCLES     = 625000,
  parameter int SYNC_STAGES   = 2,
  localparam int ADDR_W       = 8 + PAGE_SEL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapPins,
  output logic              sdaOe,
  output logic              busy,
  input  logic [ADDR_W-1:0] memRdAddr,
  output logic [7:0]        memRdData
);

  dpCmd_t     cmd;
  logic       sdaBit;
  logic [7:0] rxNext;
  logic       pageHasData;

  eewr_ctrl #(
    .PAGE_SEL_BITS(PAGE_SEL_BITS),
    .WR_CYCLES    (WR_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .strapPins  (strapPins),
    .rxNext     (rxNext),
    .pageHasData(pageHasData),
    .cmd        (cmd),
    .sdaBit     (sdaBit),
    .sdaOe      (sdaOe),
    .busy       (busy)
  );

  eewr_data #(
    .PAGE_SEL_BITS(PAGE_SEL_BITS),
    .PAGE_BITS    (PAGE_BITS)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .sdaBit     (sdaBit),
    .rxNext     (rxNext),
    .pageHasData(pageHasData),
    .memRdAddr  (memRdAddr),
    .memRdData  (memRdData)
  );

endmodule

// File: tb/eeprom_write_target_tb_top.sv
`timescale 1ns/1ps
module eeprom_write_target_tb_top;

  localparam int Q   = 10;    // quarter SCL period in system clocks
  localparam int WRC = 3000;  // write cycle length used here

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] strap = 3'b110;
  logic [9:0] rdAddr = '0;
  logic       sdaOe, busy, sdaBus;
  logic [7:0] rdData;

  assign sdaBus = sdaM & ~sdaOe;

  always #4 clk = ~clk;  // 125 MHz

  eeprom_write_target #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .strapPins(strap), .sdaOe(sdaOe), .busy(busy),
    .memRdAddr(rdAddr), .memRdData(rdData)
  );

  typedef struct {
    string tag;
    int    val;
  } item_t;

  item_t expQ[$];
  item_t actQ[$];
  event  actEv;
  int    total = 0;
  int    bad = 0;
  int    busyCnt = 0;

  // monitor: pops results and compares with the expected queue
  initial begin
    item_t a, e;
    forever begin
      @(actEv);
      while (actQ.size() > 0) begin
        a = actQ.pop_front();
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL %s: actual %0d, expected <none>", a.tag, a.val);
        end else begin
          e = expQ.pop_front();
          if (e.val != a.val) begin
            bad++;
            $display("FAIL %s: actual %0d, expected %0d", a.tag, a.val, e.val);
          end
        end
      end
    end
  end

  always @(negedge clk) if (busy) busyCnt++;

  task automatic pushExp(input string tag, input int v);
    expQ.push_back('{tag, v});
  endtask

  task automatic pushAct(input string tag, input int v);
    actQ.push_back('{tag, v});
    ->actEv;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    pushExp(tag, exp);
    pushAct(tag, got);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wq();
    sclM = 1'b1; wq();
    sdaM = 1'b0; wq();
    sclM = 1'b0; wq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq();
    sclM = 1'b1; wq();
    sdaM = 1'b1; wq();
  endtask

  // expAck: 0 = acknowledged (line pulled low), 1 = not acknowledged
  task automatic sendByte(input logic [7:0] b, input int expAck, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; wq();
      sclM = 1'b1; wq(); wq();
      sclM = 1'b0; wq();
    end
    sdaM = 1'b1;
    pushExp(tag, expAck);
    wq();
    sclM = 1'b1; wq();
    pushAct(tag, int'(sdaBus));
    wq();
    sclM = 1'b0; wq();
  endtask

  task automatic checkMem(input logic [9:0] addr, input int exp, input string tag);
    @(negedge clk) rdAddr = addr;
    @(negedge clk);
    check(tag, int'(rdData), exp);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog: actual timeout, expected completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 sdaOe after reset", int'(sdaOe), 0);
    check("R1 busy after reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // byte write, page bits 01, strap[1:0] differ from them (R2, R5, R8)
    busyCnt = 0;
    busStart();
    sendByte(8'hAA, 0, "R2 device byte ack");
    check("R2 line released after ack", int'(sdaOe), 0);
    sendByte(8'h35, 0, "R5 word address ack");
    sendByte(8'h5C, 0, "R5 data ack");
    busStop();
    check("R8 busy after stop", int'(busy), 1);
    waitIdle();
    check("R8 busy length", busyCnt, WRC);
    checkMem(10'h135, 8'h5C, "R5 R12 byte in array");

    // page wrap (R6)
    busStart();
    sendByte(8'hA8, 0, "R6 device ack");
    sendByte(8'h5E, 0, "R6 word ack");
    sendByte(8'h11, 0, "R6 data0");
    sendByte(8'h22, 0, "R6 data1");
    sendByte(8'h33, 0, "R6 data2");
    sendByte(8'h44, 0, "R6 data3");
    busStop();
    waitIdle();
    checkMem(10'h05E, 8'h11, "R6 offset 14");
    checkMem(10'h05F, 8'h22, "R6 offset 15");
    checkMem(10'h050, 8'h33, "R6 wrapped to offset 0");
    checkMem(10'h051, 8'h44, "R6 offset 1");

    // overflow past 16 bytes (R7), then traffic during the cycle (R10)
    busStart();
    sendByte(8'hAC, 0, "R7 device ack");
    sendByte(8'h40, 0, "R7 word ack");
    for (int i = 0; i < 18; i++) sendByte(8'(8'h80 + i), 0, "R7 data ack");
    busStop();
    busStart();
    sendByte(8'hAA, 1, "R10 poll refused while busy");
    sendByte(8'h35, 1, "R10 word ignored");
    sendByte(8'hEE, 1, "R10 data ignored");
    busStop();
    check("R10 still busy", int'(busy), 1);
    waitIdle();
    checkMem(10'h240, 8'h90, "R7 offset 0 overwritten");
    checkMem(10'h241, 8'h91, "R7 offset 1 overwritten");
    checkMem(10'h242, 8'h82, "R7 offset 2 kept");
    checkMem(10'h24F, 8'h8F, "R7 offset 15 kept");
    checkMem(10'h135, 8'h5C, "R10 array unchanged");

    // poll after the cycle, stop without data (R9)
    busStart();
    sendByte(8'hAA, 0, "R10 poll ack after cycle");
    sendByte(8'h10, 0, "R9 word ack");
    busStop();
    wq();
    check("R9 no write cycle", int'(busy), 0);

    // mismatches (R3)
    busStart();
    sendByte(8'hA2, 1, "R3 strap bit mismatch");
    sendByte(8'h00, 1, "R3 following byte silent");
    busStop();
    wq();
    check("R3 no write cycle", int'(busy), 0);
    busStart();
    sendByte(8'hBA, 1, "R3 type mismatch");
    busStop();

    // read select (R4)
    busStart();
    sendByte(8'hA9, 0, "R4 read device ack");
    sendByte(8'h55, 1, "R4 byte after read silent");
    busStop();
    wq();
    check("R4 no write cycle", int'(busy), 0);

    // repeated start drops partial page (R11); other strap[1:0]
    strap = 3'b101;
    busStart();
    sendByte(8'hA8, 0, "R11 device ack");
    sendByte(8'h50, 0, "R11 word ack");
    sendByte(8'h99, 0, "R11 partial data ack");
    busStart();
    sendByte(8'hA8, 0, "R11 device ack again");
    sendByte(8'h60, 0, "R11 new word ack");
    sendByte(8'h66, 0, "R11 new data ack");
    busStop();
    check("R11 write cycle runs", int'(busy), 1);
    waitIdle();
    checkMem(10'h060, 8'h66, "R11 new byte stored");
    checkMem(10'h050, 8'h33, "R11 discarded byte absent");

    repeat (10) @(negedge clk);
    if (expQ.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R12 scoreboard: actual %0d pending, expected 0", expQ.size());
    end
    finishRun();
  end

endmodule